// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block manages one port of general-purpose pins behind a small word-addressed register bus. Every pin carries a set of one-bit attributes: GPIO ownership, output enable, output data, pull-up, pull-down, open-drain, input filter enable, filter type and interrupt enable. Each attribute is changed only through a pair of write-one-to-act addresses, so software never needs a read-modify-write to touch a single pin.

A pin that GPIO does not own is handed to one of four peripheral functions, A to D. Two read/write select words choose the function. The block then routes that function's output and output-enable to the pad. For GPIO pins it drives the output latch, but only while the pin's output is enabled. The pad levels pass through a synchronizer and can always be read, whoever owns the pin.

The filter circuit, pads, peripherals and interrupt logic live outside the block. The block hands them per-pin control bits and a debounce divisor.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Attribute k (order: 0 ownership, 1 output enable, 2 output data, 3 pull-up, 4 pull-down, 5 open-drain, 6 filter enable, 7 filter type, 8 interrupt enable) has its set address at 3k, its clear address at 3k+1 and its status address at 3k+2. A write sets, or clears, exactly the bits that are 1 in the write data and leaves the other bits unchanged.
- R2: An ownership bit of 1 gives the pin to GPIO. A bit of 0 gives the pin to the selected peripheral function, whose output and output-enable then appear on `pad_out` and `pad_oe`.
- R3: The select words sit at address 27 (low bit) and address 28 (high bit). They are read/write. The per-pin code {high,low} picks the function: 00 = A, 01 = B, 10 = C, 11 = D. Function f drives pin p from bit f*NPINS+p of `periph_out` and `periph_oe`.
- R4: A GPIO-owned pin drives `pad_oe` from its output-enable bit. It drives `pad_out` from its data latch while the output is enabled, and drives 0 while the output is disabled.
- R5: Address 31 returns the pad levels through a two-flop synchronizer. A level applied before a clock edge is readable after the second edge and not after the first. This holds for every pin, whoever owns it.
- R6: `pad_pd` follows the pull-down bits. `pad_pu` follows the pull-up bits, except that it is 0 wherever the pull-down bit is also 1.
- R7: `pad_od` is the open-drain bit gated by the pin's effective `pad_oe`.
- R8: `flt_en` follows attribute 6. `flt_deb` follows attribute 7, where 1 means debounce and 0 means glitch filtering. The divisor at address 30 is read/write and keeps only its low DIV_W bits, which drive `deb_div`.
- R9: The word at address 29 is read/write. A set bit raises `schmitt_dis` for that pin.
- R10: `irq_en` follows attribute 8, so a write to address 25 masks the chosen interrupt-enable bits.
- R11: Reset makes every pin GPIO-owned with its output disabled and its pull-up on. It also clears the data, pull-down, open-drain, filter, interrupt, select, Schmitt and divisor state.
- R12: A read of any set or clear address returns 0. A status address returns the attribute's current bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | NPINS | Write data / pin mask |
| bus_rdata | output | NPINS | Read data for `bus_addr` (combinational) |
| pad_in | input | NPINS | Raw pad levels |
| periph_out | input | 4*NPINS | Peripheral outputs, function-major |
| periph_oe | input | 4*NPINS | Peripheral output enables, function-major |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| pad_od | output | NPINS | Open-drain control |
| pad_pu | output | NPINS | Pull-up control |
| pad_pd | output | NPINS | Pull-down control |
| flt_en | output | NPINS | Input filter enable |
| flt_deb | output | NPINS | Filter type, 1 = debounce |
| schmitt_dis | output | NPINS | Schmitt trigger disable |
| deb_div | output | DIV_W | Debounce divisor |
| irq_en | output | NPINS | Interrupt enable mask |

## Verification
The bench builds the block with its defaults: NPINS = 32 and DIV_W = 14. With these values a full 32-bit mask covers every pin. A divisor write of all ones shows the truncation to 14 bits. Four low pins, each given a different select code, exercise all four function routes in one observation. The upper pins stay GPIO-owned and show the output-enable gating and the pull priority on the same words.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W   = 5;
    localparam int NUM_FUNC = 4;
    localparam int NUM_ATTR = 9;

    typedef enum logic [3:0] {
        ATTR_OWN  = 4'd0,
        ATTR_OE   = 4'd1,
        ATTR_DAT  = 4'd2,
        ATTR_PU   = 4'd3,
        ATTR_PD   = 4'd4,
        ATTR_OD   = 4'd5,
        ATTR_FLT  = 4'd6,
        ATTR_FTYP = 4'd7,
        ATTR_IRQ  = 4'd8
    } attr_e;

    typedef enum logic [1:0] {
        ACC_SET  = 2'd0,
        ACC_CLR  = 2'd1,
        ACC_STS  = 2'd2,
        ACC_NONE = 2'd3
    } acc_e;

    localparam logic [ADDR_W-1:0] ADDR_SEL_LO = 5'd27;
    localparam logic [ADDR_W-1:0] ADDR_SEL_HI = 5'd28;
    localparam logic [ADDR_W-1:0] ADDR_SCHM   = 5'd29;
    localparam logic [ADDR_W-1:0] ADDR_DIV    = 5'd30;
    localparam logic [ADDR_W-1:0] ADDR_PIN    = 5'd31;
    localparam logic [ADDR_W-1:0] ATTR_SPAN   = 5'd27;

    typedef struct packed {
        logic       is_attr;
        logic [3:0] idx;
        acc_e       acc;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.is_attr = (a < ATTR_SPAN);
        d.idx     = 4'(a / 5'd3);
        d.acc     = d.is_attr ? acc_e'(2'(a % 5'd3)) : ACC_NONE;
        return d;
    endfunction

    function automatic bit attr_resets_high(input int k);
        return (k == int'(ATTR_OWN)) || (k == int'(ATTR_PU));
    endfunction

endpackage

// File: rtl/gpio_attr_reg.sv
module gpio_attr_reg #(
    parameter int W        = 32,
    parameter bit RST_HIGH = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] mask,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= {W{RST_HIGH}};
        end else if (set_en) begin
            q <= q | mask;
        end else if (clr_en) begin
            q <= q & ~mask;
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_port_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]          own,
    input  logic [W-1:0]          oe,
    input  logic [W-1:0]          dat,
    input  logic [W-1:0]          od,
    input  logic [W-1:0]          pu,
    input  logic [W-1:0]          pd,
    input  logic [W-1:0]          sel_lo,
    input  logic [W-1:0]          sel_hi,
    input  logic [NUM_FUNC*W-1:0] periph_out,
    input  logic [NUM_FUNC*W-1:0] periph_oe,
    output logic [W-1:0]          pad_out,
    output logic [W-1:0]          pad_oe,
    output logic [W-1:0]          pad_od,
    output logic [W-1:0]          pad_pu,
    output logic [W-1:0]          pad_pd
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        logic [1:0]          code;
        logic [NUM_FUNC-1:0] f_out;
        logic [NUM_FUNC-1:0] f_oe;

        assign code = {sel_hi[p], sel_lo[p]};

        for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
            assign f_out[f] = periph_out[f*W + p];
            assign f_oe[f]  = periph_oe[f*W + p];
        end

        // GPIO drives the latch only while its output is on
        assign pad_oe[p]  = own[p] ? oe[p] : f_oe[code];
        assign pad_out[p] = own[p] ? (oe[p] & dat[p]) : f_out[code];
        assign pad_od[p]  = od[p] & pad_oe[p];
        // pull-down wins when both pulls are requested
        assign pad_pu[p]  = pu[p] & ~pd[p];
        assign pad_pd[p]  = pd[p];
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int DIV_W = 14
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [NPINS-1:0]          bus_wdata,
    output logic [NPINS-1:0]          bus_rdata,
    input  logic [NPINS-1:0]          pad_in,
    input  logic [NUM_FUNC*NPINS-1:0] periph_out,
    input  logic [NUM_FUNC*NPINS-1:0] periph_oe,
    output logic [NPINS-1:0]          pad_out,
    output logic [NPINS-1:0]          pad_oe,
    output logic [NPINS-1:0]          pad_od,
    output logic [NPINS-1:0]          pad_pu,
    output logic [NPINS-1:0]          pad_pd,
    output logic [NPINS-1:0]          flt_en,
    output logic [NPINS-1:0]          flt_deb,
    output logic [NPINS-1:0]          schmitt_dis,
    output logic [DIV_W-1:0]          deb_div,
    output logic [NPINS-1:0]          irq_en
);
    localparam int DIV_PAD = NPINS - DIV_W;

    dec_t                           dec;
    logic [NUM_ATTR-1:0][NPINS-1:0] attr_q;
    logic [NPINS-1:0]               sel_lo_q, sel_hi_q, schm_q, pin_sync;
    logic [DIV_W-1:0]               div_q;

    assign dec = decode(bus_addr);

    for (genvar k = 0; k < NUM_ATTR; k++) begin : g_attr
        gpio_attr_reg #(
            .W       (NPINS),
            .RST_HIGH(attr_resets_high(k))
        ) i_reg (
            .clk   (clk),
            .rst   (rst),
            .set_en(bus_wr && dec.is_attr && dec.idx == 4'(k) && dec.acc == ACC_SET),
            .clr_en(bus_wr && dec.is_attr && dec.idx == 4'(k) && dec.acc == ACC_CLR),
            .mask  (bus_wdata),
            .q     (attr_q[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_lo_q <= '0;
            sel_hi_q <= '0;
            schm_q   <= '0;
            div_q    <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_SEL_LO: sel_lo_q <= bus_wdata;
                ADDR_SEL_HI: sel_hi_q <= bus_wdata;
                ADDR_SCHM:   schm_q   <= bus_wdata;
                ADDR_DIV:    div_q    <= bus_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    gpio_in_sync #(.W(NPINS), .STAGES(2)) i_sync (
        .clk(clk),
        .rst(rst),
        .d  (pad_in),
        .q  (pin_sync)
    );

    gpio_pin_mux #(.W(NPINS)) i_mux (
        .own       (attr_q[ATTR_OWN]),
        .oe        (attr_q[ATTR_OE]),
        .dat       (attr_q[ATTR_DAT]),
        .od        (attr_q[ATTR_OD]),
        .pu        (attr_q[ATTR_PU]),
        .pd        (attr_q[ATTR_PD]),
        .sel_lo    (sel_lo_q),
        .sel_hi    (sel_hi_q),
        .periph_out(periph_out),
        .periph_oe (periph_oe),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_od    (pad_od),
        .pad_pu    (pad_pu),
        .pad_pd    (pad_pd)
    );

    always_comb begin
        bus_rdata = '0;
        if (dec.is_attr) begin
            if (dec.acc == ACC_STS) bus_rdata = attr_q[dec.idx];
        end else begin
            case (bus_addr)
                ADDR_SEL_LO: bus_rdata = sel_lo_q;
                ADDR_SEL_HI: bus_rdata = sel_hi_q;
                ADDR_SCHM:   bus_rdata = schm_q;
                ADDR_DIV:    bus_rdata = {{DIV_PAD{1'b0}}, div_q};
                ADDR_PIN:    bus_rdata = pin_sync;
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign flt_en      = attr_q[ATTR_FLT];
    assign flt_deb     = attr_q[ATTR_FTYP];
    assign irq_en      = attr_q[ATTR_IRQ];
    assign schmitt_dis = schm_q;
    assign deb_div     = div_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  bus_rdata,
    input logic [NPINS-1:0]  pad_in,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_od,
    input logic [NPINS-1:0]  pad_pu,
    input logic [NPINS-1:0]  pad_pd,
    input logic [NPINS-1:0]  oe_q
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    a_r1_set_keeps_rest: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 5'd3) |=> oe_q == ($past(oe_q) | $past(bus_wdata)));

    a_r1_clr_keeps_rest: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 5'd4) |=> oe_q == ($past(oe_q) & ~$past(bus_wdata)));

    a_r5_pin_two_flop: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && bus_addr == ADDR_PIN) |-> bus_rdata == $past(pad_in, 2));

    a_r6_pulls_exclusive: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_pd) == '0);

    a_r7_od_needs_oe: assert property (@(posedge clk) disable iff (rst)
        (pad_od & ~pad_oe) == '0);

    a_r12_action_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr < ATTR_SPAN && (bus_addr % 5'd3) != 5'd2) |-> bus_rdata == '0);
endmodule

bind gpio_port_ctrl gpio_port_chk #(.NPINS(NPINS)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_in   (pad_in),
    .pad_oe   (pad_oe),
    .pad_od   (pad_od),
    .pad_pu   (pad_pu),
    .pad_pd   (pad_pd),
    .oe_q     (attr_q[gpio_port_pkg::ATTR_OE])
);

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;
    localparam int N  = 32;
    localparam int DW = 14;
    localparam int NV = 15;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_wr = 1'b0;
    logic [4:0]     bus_addr = '0;
    logic [N-1:0]   bus_wdata = '0;
    logic [N-1:0]   bus_rdata;
    logic [N-1:0]   pad_in = '0;
    logic [4*N-1:0] periph_out = '0;
    logic [4*N-1:0] periph_oe = '0;
    logic [N-1:0]   pad_out, pad_oe, pad_od, pad_pu, pad_pd;
    logic [N-1:0]   flt_en, flt_deb, schmitt_dis, irq_en;
    logic [DW-1:0]  deb_div;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    gpio_port_ctrl #(.NPINS(N), .DIV_W(DW)) i_gpio_port_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .periph_out(periph_out), .periph_oe(periph_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .flt_en(flt_en), .flt_deb(flt_deb),
        .schmitt_dis(schmitt_dis), .deb_div(deb_div), .irq_en(irq_en)
    );

    // {write address, write data, read address, expected read}
    localparam logic [79:0] VEC [NV] = '{
        {8'd3,  32'h0000_00F0, 8'd5,  32'h0000_00F0},  // R1 set
        {8'd3,  32'h0000_0F00, 8'd5,  32'h0000_0FF0},  // R1 others kept
        {8'd4,  32'h0000_0030, 8'd5,  32'h0000_0FC0},  // R1 clear
        {8'd6,  32'hA5A5_0000, 8'd8,  32'hA5A5_0000},  // R1 data set
        {8'd7,  32'h0005_0000, 8'd8,  32'hA5A0_0000},  // R1 data clear
        {8'd10, 32'h0000_FFFF, 8'd11, 32'hFFFF_0000},  // R1 pull-up clear
        {8'd12, 32'h0001_0001, 8'd14, 32'h0001_0001},  // R1 pull-down set
        {8'd18, 32'h8000_0001, 8'd20, 32'h8000_0001},  // R8 filter on
        {8'd21, 32'h8000_0000, 8'd23, 32'h8000_0000},  // R8 debounce
        {8'd24, 32'hFFFF_FFFF, 8'd26, 32'hFFFF_FFFF},  // R10 enable
        {8'd25, 32'h0F0F_0F0F, 8'd26, 32'hF0F0_F0F0},  // R10 mask
        {8'd27, 32'h1234_5678, 8'd27, 32'h1234_5678},  // R3 select rw
        {8'd30, 32'hFFFF_FFFF, 8'd30, 32'h0000_3FFF},  // R8 divisor width
        {8'd1,  32'h0000_000F, 8'd2,  32'hFFFF_FFF0},  // R2 ownership clear
        {8'd3,  32'h0000_0000, 8'd3,  32'h0000_0000}   // R12 set reads zero
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic reset_checks();
        logic [31:0] r;
        bus_read(5'd2, r);  check("R11 ownership", r, 32'hFFFF_FFFF);
        bus_read(5'd5, r);  check("R11 output enable", r, 32'h0);
        bus_read(5'd11, r); check("R11 pull-up", r, 32'hFFFF_FFFF);
        bus_read(5'd14, r); check("R11 pull-down", r, 32'h0);
        bus_read(5'd27, r); check("R11 select low", r, 32'h0);
        bus_read(5'd28, r); check("R11 select high", r, 32'h0);
        bus_read(5'd30, r); check("R11 divisor", r, 32'h0);
        check("R11 pad_oe", pad_oe, 32'h0);
        check("R11 pad_pu", pad_pu, 32'hFFFF_FFFF);
        check("R11 flt_en", flt_en, 32'h0);
        check("R11 irq_en", irq_en, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] r;
        for (int f = 0; f < 4; f++) begin
            periph_out[f*N +: N] = 32'h1 << f;
            periph_oe[f*N +: N]  = '1;
        end
        @(negedge clk);
        do_reset();
        reset_checks();

        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i][76:72], VEC[i][71:40]);
            bus_read(VEC[i][36:32], r);
            check($sformatf("R1/R12 vector %0d", i), r, VEC[i][31:0]);
        end

        // R3: pins 0..3 take codes 00,01,10,11
        bus_write(5'd27, 32'h0000_000A);
        bus_write(5'd28, 32'h0000_000C);
        check("R3 each code routes its function", pad_out & 32'hF, 32'hF);
        check("R2 peripheral oe on pad", pad_oe & 32'hF, 32'hF);
        bus_write(5'd27, 32'h0);
        bus_write(5'd28, 32'h0);
        check("R3 code 00 selects A", pad_out & 32'hF, 32'h1);

        // R4: GPIO pins drive latch only while enabled
        bus_write(5'd6, 32'h0000_0140);
        check("R4 gpio pad_out", pad_out & 32'hFFFF_FFF0, 32'h0000_0140);
        check("R4 gpio pad_oe", pad_oe & 32'hFFFF_FFF0, 32'h0000_0FC0);
        bus_write(5'd0, 32'h0000_000F);
        check("R2 back to gpio oe", pad_oe & 32'hF, 32'h0);
        check("R2 back to gpio out", pad_out & 32'hF, 32'h0);

        // R7 open-drain gated by pad_oe
        bus_write(5'd15, 32'h0001_0100);
        check("R7 pad_od", pad_od, 32'h0000_0100);

        // R6 pull priority
        check("R6 pad_pd", pad_pd, 32'h0001_0001);
        bus_write(5'd9, 32'h0000_0001);
        check("R6 pd beats pu", pad_pu, 32'hFFFE_0000);
        bus_write(5'd13, 32'h0000_0001);
        check("R6 pu after pd cleared", pad_pu, 32'hFFFE_0001);

        // R5 two-flop synchronizer, ownership independent
        bus_write(5'd1, 32'h0000_0003);
        bus_addr = 5'd31;
        pad_in = 32'hDEAD_BEEF;
        @(posedge clk); @(negedge clk);
        bus_read(5'd31, r); check("R5 not after one edge", r, 32'h0);
        @(posedge clk); @(negedge clk);
        bus_read(5'd31, r); check("R5 after two edges", r, 32'hDEAD_BEEF);

        // R8 filter outputs
        check("R8 flt_en", flt_en, 32'h8000_0001);
        check("R8 flt_deb", flt_deb, 32'h8000_0000);
        check("R8 deb_div", {18'h0, deb_div}, 32'h0000_3FFF);
        bus_write(5'd22, 32'h8000_0000);
        check("R8 glitch chosen", flt_deb, 32'h0);

        // R9 Schmitt
        bus_write(5'd29, 32'h00FF_00FF);
        check("R9 schmitt_dis", schmitt_dis, 32'h00FF_00FF);
        bus_read(5'd29, r); check("R9 readback", r, 32'h00FF_00FF);

        // R10 interrupt mask
        check("R10 irq_en", irq_en, 32'hF0F0_F0F0);

        // R12 action addresses read zero, status current
        bus_read(5'd0, r);  check("R12 set addr reads 0", r, 32'h0);
        bus_read(5'd25, r); check("R12 clr addr reads 0", r, 32'h0);
        bus_read(5'd17, r); check("R12 od status", r, 32'h0001_0100);

        // R11 reset mid-run
        do_reset();
        reset_checks();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule